// File: doc/BRIEF.md
# Link Self-Test Pattern Checker

This block is the receive half of a built-in self-test for an 8B/10B serial link. It sits after the decoder and sees one decoded byte per byte time. Each byte arrives with a valid strobe and carries 8 data bits, a special-character flag and a code-violation flag. When normal operation is running, the block passes these bytes through to its registered outputs. When the active-low test enable is pulled low, the block switches to checking. It first hunts for the loop marker character. From then on it regenerates the expected loop pattern locally and compares each received byte against it.

While checking, the data and special outputs carry the expected byte, which is useful for debug. The flag output is high for exactly one cycle for each byte that fails its comparison. The ready output pulses once each time a loop completes, so an external counter can follow progress. Each loop contains violations that the transmitter injects on purpose. At those positions a violation is the correct result, and a missing violation counts as an error. The decode-select output forces decoded data to be used while the test is enabled, even when the receiver is otherwise set to bypass.

The block has three states, named in `lst_state_t`:
- `ST_IDLE` is normal pass-through. Enable going low takes it to `ST_HUNT`.
- `ST_HUNT` waits for the marker. When the marker arrives it moves to `ST_CHECK`.
- `ST_CHECK` compares bytes. Enable going high returns from either `ST_HUNT` or `ST_CHECK` to `ST_IDLE`.

Top module: `link_selftest_chk`

## Requirements
- R1: With `test_en_n` high, the state is `ST_IDLE` after the next clock, and the outputs return to pass-through. Driving `test_en_n` low in `ST_IDLE` moves to `ST_HUNT`.
- R2: In `ST_HUNT`, `rdy` is high. A valid byte with `rx_special`=1, `rx_viol`=0 and `rx_data`=8'hBC is the marker. It moves the block to `ST_CHECK` and drives `rdy` low one clock later.
- R3: The pattern has 256 positions per loop. Position 0 is the marker (8'hBC, special). Positions 1..255 are non-special data bytes from an 8-bit LFSR. The LFSR is seeded with 8'h01 at position 1, and its next value is {s[6:0], s[7]^s[5]^s[4]^s[3]}. The position advances on each valid byte.
- R4: In `ST_CHECK`, a valid byte whose data or special flag differs from the expected byte raises `q_flag` for exactly one cycle. A matching byte leaves `q_flag` low.
- R5: Violations are injected at the positions p with p mod 64 = 32. At these positions a received violation is not an error, a missing violation is an error, and the data and special bits are ignored.
- R6: In `ST_CHECK`, `rdy` goes high for one cycle after the position-0 byte of each completed loop. It is low after every other byte.
- R7: In `ST_CHECK`, `q_data` and `q_special` show the expected byte for the byte just checked.
- R8: `dec_sel` is high whenever `bypass` is low or `test_en_n` is low, in the same cycle.
- R9: Before the marker has been seen (`ST_HUNT`), `q_flag` stays low, even for violations or wrong bytes.
- R10: In `ST_IDLE`, a valid byte is registered onto `q_data`/`q_special`. `q_flag` follows `rx_viol` and `rdy` follows `byte_vld`. A cycle with no valid byte holds the data and drops `q_flag` and `rdy`.
- R11: A violation received at a position where none is injected is an error.
- R12: After reset, the state is `ST_IDLE` and all registered outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| test_en_n | input | 1 | Active-low self-test enable |
| bypass | input | 1 | Receiver bypass (undecoded) selection |
| byte_vld | input | 1 | One strobe per decoded byte |
| rx_data | input | 8 | Decoded data byte |
| rx_special | input | 1 | Byte is a special character |
| rx_viol | input | 1 | Decoder reported a code violation |
| q_data | output | 8 | Received byte (normal) or expected byte (checking) |
| q_special | output | 1 | Received or expected special flag |
| q_flag | output | 1 | Violation (normal) or mismatch (checking) |
| rdy | output | 1 | Byte ready (normal), hunting level, or loop pulse |
| dec_sel | output | 1 | Select decoded data path |

## Verification
Every registered result (`q_data`, `q_special`, `q_flag`, `rdy`) belongs to the byte presented at the clock edge just before it appears, so it is due one clock after the stimulus. `dec_sel` is combinational and is due in the same cycle as its inputs. The bench drives inputs 2 ns after a rising edge and reads the outputs 2 ns after the following rising edge. Each check therefore sees exactly the response to the byte it just drove, and `dec_sel` is still looking at that byte's inputs. The loop test runs its own LFSR model and compares every byte, position by position, including the loop-end ready pulse.

// File: rtl/lst_pkg.sv
package lst_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HUNT  = 2'd1,
        ST_CHECK = 2'd2
    } lst_state_t;

    // x^8 + x^6 + x^5 + x^4 + 1, maximal length (period 255)
    function automatic logic [7:0] lfsr8_next(input logic [7:0] s);
        return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
    endfunction

endpackage

// File: rtl/lst_pattern_gen.sv
module lst_pattern_gen #(
    parameter int          DW        = 8,
    parameter logic [7:0]  SEED      = 8'h01,
    parameter logic [7:0]  MARK      = 8'hBC,
    parameter int          VSTRIDE_LG = 6,
    parameter int          VOFFSET   = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          step,
    output logic [DW-1:0] exp_data,
    output logic          exp_special,
    output logic          exp_viol,
    output logic          at_marker
);
    import lst_pkg::*;

    localparam logic [VSTRIDE_LG-1:0] VOFF = VOFFSET[VSTRIDE_LG-1:0];

    logic [DW-1:0] pos;
    logic [7:0]    lfsr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos  <= '0;
            lfsr <= SEED;
        end else if (restart) begin
            pos  <= DW'(1);
            lfsr <= SEED;
        end else if (step) begin
            pos  <= pos + 1'b1;
            lfsr <= (pos == '0) ? SEED : lfsr8_next(lfsr);
        end
    end

    assign at_marker   = (pos == '0);
    assign exp_data    = at_marker ? MARK : lfsr;
    assign exp_special = at_marker;
    assign exp_viol    = !at_marker && (pos[VSTRIDE_LG-1:0] == VOFF);

endmodule

// File: rtl/lst_compare.sv
module lst_compare #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] rx_data,
    input  logic          rx_special,
    input  logic          rx_viol,
    input  logic [DW-1:0] exp_data,
    input  logic          exp_special,
    input  logic          exp_viol,
    output logic          miss
);
    always_comb begin
        if (exp_viol) begin
            miss = !rx_viol;
        end else begin
            miss = rx_viol || (rx_data != exp_data) || (rx_special != exp_special);
        end
    end
endmodule

// File: rtl/link_selftest_chk.sv
module link_selftest_chk #(
    parameter int         DW         = 8,
    parameter logic [7:0] SEED       = 8'h01,
    parameter logic [7:0] MARK       = 8'hBC,
    parameter int         VSTRIDE_LG = 6,
    parameter int         VOFFSET    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          test_en_n,
    input  logic          bypass,
    input  logic          byte_vld,
    input  logic [DW-1:0] rx_data,
    input  logic          rx_special,
    input  logic          rx_viol,
    output logic [DW-1:0] q_data,
    output logic          q_special,
    output logic          q_flag,
    output logic          rdy,
    output logic          dec_sel
);
    import lst_pkg::*;

    lst_state_t    state, state_nx;
    logic          marker_hit;
    logic          gen_restart, gen_step;
    logic [DW-1:0] exp_data;
    logic          exp_special, exp_viol, at_marker, miss;

    assign marker_hit  = byte_vld && rx_special && !rx_viol && (rx_data == MARK);
    assign gen_restart = (state == ST_HUNT) && !test_en_n && marker_hit;
    assign gen_step    = (state == ST_CHECK) && !test_en_n && byte_vld;
    assign dec_sel     = !bypass || !test_en_n;

    lst_pattern_gen #(
        .DW(DW), .SEED(SEED), .MARK(MARK),
        .VSTRIDE_LG(VSTRIDE_LG), .VOFFSET(VOFFSET)
    ) u_gen (
        .clk(clk), .rst_n(rst_n),
        .restart(gen_restart), .step(gen_step),
        .exp_data(exp_data), .exp_special(exp_special),
        .exp_viol(exp_viol), .at_marker(at_marker)
    );

    lst_compare #(.DW(DW)) u_cmp (
        .rx_data(rx_data), .rx_special(rx_special), .rx_viol(rx_viol),
        .exp_data(exp_data), .exp_special(exp_special), .exp_viol(exp_viol),
        .miss(miss)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        if (test_en_n) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  state_nx = ST_HUNT;
                ST_HUNT:  if (marker_hit) state_nx = ST_CHECK;
                ST_CHECK: state_nx = ST_CHECK;
                default:  state_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_data    <= '0;
            q_special <= 1'b0;
            q_flag    <= 1'b0;
            rdy       <= 1'b0;
        end else if (test_en_n) begin
            if (byte_vld) begin
                q_data    <= rx_data;
                q_special <= rx_special;
            end
            q_flag <= byte_vld && rx_viol;
            rdy    <= byte_vld;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    q_flag <= 1'b0;
                    rdy    <= 1'b1;
                end
                ST_HUNT: begin
                    if (byte_vld) begin
                        q_data    <= rx_data;
                        q_special <= rx_special;
                    end
                    q_flag <= 1'b0;
                    rdy    <= !marker_hit;
                end
                ST_CHECK: begin
                    if (byte_vld) begin
                        q_data    <= exp_data;
                        q_special <= exp_special;
                    end
                    q_flag <= byte_vld && miss;
                    rdy    <= byte_vld && at_marker;
                end
                default: begin
                    q_flag <= 1'b0;
                    rdy    <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/lst_checker.sv
module lst_checker (
    input logic               clk,
    input logic               rst_n,
    input logic               test_en_n,
    input logic               byte_vld,
    input logic               rdy,
    input logic               q_flag,
    input lst_pkg::lst_state_t state
);
    import lst_pkg::*;

    a_r1_release_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        test_en_n |=> (state == ST_IDLE));

    a_r2_hunt_ready_high: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HUNT) |-> rdy);

    a_r2_check_entry_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_CHECK) |-> !rdy);

    a_r4_flag_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_CHECK) && !test_en_n && !byte_vld) |=> !q_flag);

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_CHECK) && !test_en_n && rdy) |=> !rdy);

    a_r9_no_flag_hunting: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_HUNT) && !test_en_n) |=> !q_flag);

endmodule

bind link_selftest_chk lst_checker u_chk (
    .clk(clk), .rst_n(rst_n), .test_en_n(test_en_n), .byte_vld(byte_vld),
    .rdy(rdy), .q_flag(q_flag), .state(state)
);

// File: tb/sim_link_selftest_chk.sv
module sim_link_selftest_chk;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       test_en_n = 1'b1;
    logic       bypass = 1'b0;
    logic       byte_vld = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       rx_special = 1'b0;
    logic       rx_viol = 1'b0;
    logic [7:0] q_data;
    logic       q_special, q_flag, rdy, dec_sel;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    link_selftest_chk u0 (
        .clk(clk), .rst_n(rst_n), .test_en_n(test_en_n), .bypass(bypass),
        .byte_vld(byte_vld), .rx_data(rx_data), .rx_special(rx_special),
        .rx_viol(rx_viol), .q_data(q_data), .q_special(q_special),
        .q_flag(q_flag), .rdy(rdy), .dec_sel(dec_sel)
    );

    // {bypass, vld, data, special, viol, exp_q_data, exp_special, exp_flag, exp_rdy, exp_dec}
    localparam logic [23:0] TV [6] = '{
        {1'b0, 1'b1, 8'h3C, 1'b0, 1'b0, 8'h3C, 1'b0, 1'b0, 1'b1, 1'b1},
        {1'b1, 1'b1, 8'hA5, 1'b1, 1'b0, 8'hA5, 1'b1, 1'b0, 1'b1, 1'b0},
        {1'b1, 1'b0, 8'hFF, 1'b0, 1'b1, 8'hA5, 1'b1, 1'b0, 1'b0, 1'b0},
        {1'b0, 1'b1, 8'h11, 1'b0, 1'b1, 8'h11, 1'b0, 1'b1, 1'b1, 1'b1},
        {1'b1, 1'b1, 8'hBC, 1'b1, 1'b0, 8'hBC, 1'b1, 1'b0, 1'b1, 1'b0},
        {1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'hBC, 1'b1, 1'b0, 1'b0, 1'b1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [7:0] d, input logic s, input logic x);
        byte_vld   = v;
        rx_data    = d;
        rx_special = s;
        rx_viol    = x;
        @(posedge clk);
        #2;
    endtask

    function automatic logic [7:0] model_next(input logic [7:0] s);
        return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
    endfunction

    // one loop: positions 1..255 then the closing marker at 0
    task automatic run_loop(input bit corrupt);
        logic [7:0] s;
        s = 8'h01;
        for (int k = 1; k <= 256; k++) begin
            int         p;
            logic [7:0] ed, d;
            logic       esp, iv, sp, x, eerr;
            p    = k % 256;
            ed   = (p == 0) ? 8'hBC : s;
            esp  = (p == 0);
            iv   = (p != 0) && (p % 64 == 32);
            d    = iv ? 8'h00 : ed;
            sp   = esp;
            x    = iv;
            eerr = 1'b0;
            if (corrupt) begin
                if (p == 10) begin d = d ^ 8'h04; eerr = 1'b1; end        // R4 data
                if (p == 32) begin x = 1'b0; eerr = 1'b1; end             // R5 missing
                if (p == 50) begin x = 1'b1; eerr = 1'b1; end             // R11 extra
                if (p == 70) begin sp = 1'b1; eerr = 1'b1; end            // R4 special
                if (p == 96) begin d = 8'hFF; sp = 1'b1; end              // R5 ignored
            end
            drive(1'b1, d, sp, x);
            chk("R4 R5 R11 mismatch flag", q_flag, eerr);
            chk("R3 R7 expected data", q_data, ed);
            chk("R7 expected special", q_special, esp);
            chk("R6 loop pulse", rdy, (p == 0));
            if (p != 0) s = model_next(s);
            if (corrupt && p == 100) begin
                drive(1'b0, 8'h5A, 1'b0, 1'b1);
                chk("R4 no byte no flag", q_flag, 1'b0);
                chk("R6 no byte no pulse", rdy, 1'b0);
            end
        end
    endtask

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        if (!done) begin
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        chk("R12 reset q_data", q_data, 8'h00);
        chk("R12 reset rdy", rdy, 1'b0);
        chk("R12 reset flag", q_flag, 1'b0);
        rst_n = 1'b1;
        @(posedge clk);
        #2;

        // R10 normal pass-through, R8 decode select
        for (int i = 0; i < 6; i++) begin
            bypass = TV[i][23];
            drive(TV[i][22], TV[i][21:14], TV[i][13], TV[i][12]);
            chk("R10 pass data", q_data, TV[i][11:4]);
            chk("R10 pass special", q_special, TV[i][3]);
            chk("R10 pass flag", q_flag, TV[i][2]);
            chk("R10 pass rdy", rdy, TV[i][1]);
            chk("R8 decode select", dec_sel, TV[i][0]);
        end

        // enter test while in bypass
        bypass    = 1'b1;
        test_en_n = 1'b0;
        #1;
        chk("R8 forced decode", dec_sel, 1'b1);
        drive(1'b0, 8'h00, 1'b0, 1'b0);
        chk("R1 R2 hunting rdy", rdy, 1'b1);
        drive(1'b1, 8'h55, 1'b0, 1'b1);
        chk("R9 no flag before marker", q_flag, 1'b0);
        chk("R2 rdy still high", rdy, 1'b1);
        drive(1'b1, 8'h3C, 1'b1, 1'b0);
        chk("R2 wrong special ignored", rdy, 1'b1);
        chk("R9 no flag wrong special", q_flag, 1'b0);
        drive(1'b1, 8'hBC, 1'b1, 1'b0);
        chk("R2 marker drops rdy", rdy, 1'b0);
        chk("R9 marker no flag", q_flag, 1'b0);

        run_loop(1'b0);
        run_loop(1'b1);

        // release: back to pass-through
        test_en_n = 1'b1;
        drive(1'b1, 8'h77, 1'b0, 1'b0);
        chk("R1 release data", q_data, 8'h77);
        chk("R1 release rdy", rdy, 1'b1);
        chk("R1 release flag", q_flag, 1'b0);
        chk("R8 bypass resumes", dec_sel, 1'b0);
        drive(1'b1, 8'h12, 1'b0, 1'b1);
        chk("R1 R10 normal violation", q_flag, 1'b1);

        // re-enable: hunting again, marker required anew
        test_en_n = 1'b0;
        drive(1'b1, 8'h01, 1'b0, 1'b0);
        chk("R1 re-enter hunt", rdy, 1'b1);
        drive(1'b1, 8'h02, 1'b0, 1'b0);
        chk("R9 hunt ignores data", q_flag, 1'b0);
        chk("R2 hunt rdy", rdy, 1'b1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule